// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

The arbiter gathers level-sensitive interrupt requests from a fixed group of peripheral sources and forwards at most one of them to the CPU. Software gives each source a 4-bit priority level and can block any source with its own mask bit. Every cycle the block looks at the sources that are requesting, unmasked and enabled. It picks the one with the highest level. When several share that level, the one with the lowest index wins. A source that loses is simply not forwarded. Its request stays visible and can win on a later cycle.

The winning level is compared with the CPU's current interrupt mask level. The request is passed on only when the winning level is strictly greater. In that case the block drives a request flag, the winning level and a source code. The code is a base value plus 0x20 times the source index, so handler software can use it as a branch offset.

A small register port writes and reads the priority fields and the mask. Mask bits are set through one address and cleared through a separate write-one-to-clear address.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, irqReq, irqLevel and irqCode are all 0, every mask bit is 1 (all sources blocked), and every priority field reads 0.
- R2: A source whose priority level is 0 never wins arbitration, whatever its request input does.
- R3: Among requesting, unmasked sources with a nonzero level, the one with the highest level wins.
- R4: When several eligible sources share the highest level, the one with the lowest source index wins.
- R5: A request is forwarded only when the winning level is strictly greater than cpuMask. An equal or lower winning level gives irqReq = 0.
- R6: A source whose mask bit is 1 is excluded from arbitration. A source that loses or is masked is not forgotten: it wins as soon as its request is still held and the blocking condition goes away.
- R7: A write to address NUM_PRIO_REGS (2 by default) sets each mask bit whose data bit is 1 and leaves bits written with 0 unchanged. A read of that address returns the mask in bits [NUM_SRC-1:0].
- R8: A write to address NUM_PRIO_REGS+1 (3 by default) clears each mask bit whose data bit is 1 and leaves bits written with 0 unchanged. A read of that address returns 0.
- R9: While irqReq is 1, irqCode equals CODE_BASE + index*CODE_STEP (defaults 0x200 and 0x20), and irqLevel equals the level of the winning source.
- R10: The outputs are registered. A request change in one cycle is visible on the outputs after the next rising clock edge. While irqReq is 0, irqLevel and irqCode are 0.
- R11: The level of source i sits in priority register i/4, bits [4*(i%4)+3 : 4*(i%4)], at address i/4. Those registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcReq | input | NUM_SRC | Level request from each source |
| cpuMask | input | LVL_W | CPU's current interrupt mask level |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (write and read) |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqLevel | output | LVL_W | Level of the forwarded request |
| irqCode | output | CODE_W | Source code of the forwarded request |

## Verification
The bound checker watches several properties on every cycle. A forwarded level is always above the mask level of the previous cycle. The outputs are zero whenever no request is raised. A forwarded code always lies on the 0x20 grid and names a source that was requesting. Reset leaves the request low. Which source should win cannot be checked cycle by cycle without copying the arbitration logic. The bench scenarios therefore cover level ordering, lowest-index tie-breaking, disabled levels, mask set and clear semantics, pending requests that re-emerge, and the exact one-edge output latency.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

  // strobes passed from register control to the datapath
  typedef struct packed {
    logic       prioWr;   // write a priority register
    logic       maskSet;  // write-one-to-set mask
    logic       maskClr;  // write-one-to-clear mask
    logic       rdPrio;   // read selects a priority register
    logic       rdMask;   // read selects the mask
    logic [3:0] regIdx;   // priority register index
  } arbStrobe_t;

endpackage

// File: rtl/irq_arb_ctrl.sv
`timescale 1ns/1ps
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int NUM_PRIO_REGS = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output arbStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] MASK_SET_ADDR = ADDR_W'(NUM_PRIO_REGS);
  localparam logic [ADDR_W-1:0] MASK_CLR_ADDR = ADDR_W'(NUM_PRIO_REGS + 1);

  logic isPrio;

  always_comb begin
    isPrio         = (regAddr < MASK_SET_ADDR);
    strobe.prioWr  = regWrEn && isPrio;
    strobe.maskSet = regWrEn && (regAddr == MASK_SET_ADDR);
    strobe.maskClr = regWrEn && (regAddr == MASK_CLR_ADDR);
    strobe.rdPrio  = isPrio;
    strobe.rdMask  = (regAddr == MASK_SET_ADDR);
    strobe.regIdx  = 4'(regAddr);
  end

endmodule

// File: rtl/irq_arb_datapath.sv
`timescale 1ns/1ps
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int LVL_W     = 4,
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 12,
  parameter int CODE_BASE = 'h200,
  parameter int CODE_STEP = 'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [CODE_W-1:0]  irqCode
);

  localparam int FPR   = DATA_W / LVL_W;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0][LVL_W-1:0] prioLvl;
  logic [NUM_SRC-1:0]            maskBits;
  logic [NUM_SRC-1:0]            levelOn;
  logic [NUM_SRC-1:0]            eligible;

  // priority fields, one per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prioLvl[i] <= '0;
      else if (strobe.prioWr && strobe.regIdx == 4'(i / FPR))
        prioLvl[i] <= wrData[(i % FPR)*LVL_W +: LVL_W];
    end
    assign levelOn[i] = |prioLvl[i];
  end

  // mask: separate set and clear write paths
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskBits <= '1;
    else if (strobe.maskSet)
      maskBits <= maskBits | wrData[NUM_SRC-1:0];
    else if (strobe.maskClr)
      maskBits <= maskBits & ~wrData[NUM_SRC-1:0];
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (strobe.rdMask)
      rdData[NUM_SRC-1:0] = maskBits;
    else if (strobe.rdPrio)
      for (int i = 0; i < NUM_SRC; i++)
        if (strobe.regIdx == 4'(i / FPR))
          rdData[(i % FPR)*LVL_W +: LVL_W] = prioLvl[i];
  end

  assign eligible = srcReq & ~maskBits & levelOn;

  // ascending scan with strict compare: lowest index keeps a tie
  logic [LVL_W-1:0] bestLvl;
  logic [IDX_W-1:0] bestIdx;
  logic             found;
  logic             accept;

  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && prioLvl[i] > bestLvl) begin
        bestLvl = prioLvl[i];
        bestIdx = IDX_W'(i);
        found   = 1'b1;
      end
    end
    accept = found && (bestLvl > cpuMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      irqLevel <= '0;
      irqCode  <= '0;
    end else begin
      irqReq   <= accept;
      irqLevel <= accept ? bestLvl : '0;
      irqCode  <= accept ? CODE_W'(CODE_BASE) + CODE_W'(bestIdx) * CODE_W'(CODE_STEP) : '0;
    end
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int LVL_W     = 4,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int CODE_W    = 12,
  parameter int CODE_BASE = 'h200,
  parameter int CODE_STEP = 'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [LVL_W-1:0]   cpuMask,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [CODE_W-1:0]  irqCode
);

  localparam int FPR           = DATA_W / LVL_W;
  localparam int NUM_PRIO_REGS = (NUM_SRC + FPR - 1) / FPR;

  arbStrobe_t strobe;

  irq_arb_ctrl #(
    .ADDR_W        (ADDR_W),
    .NUM_PRIO_REGS (NUM_PRIO_REGS)
  ) ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irq_arb_datapath #(
    .NUM_SRC   (NUM_SRC),
    .LVL_W     (LVL_W),
    .DATA_W    (DATA_W),
    .CODE_W    (CODE_W),
    .CODE_BASE (CODE_BASE),
    .CODE_STEP (CODE_STEP)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .srcReq   (srcReq),
    .cpuMask  (cpuMask),
    .irqReq   (irqReq),
    .irqLevel (irqLevel),
    .irqCode  (irqCode)
  );

endmodule

// File: rtl/irq_arb_checker.sv
`timescale 1ns/1ps
module irq_arb_checker #(
  parameter int NUM_SRC   = 8,
  parameter int LVL_W     = 4,
  parameter int CODE_W    = 12,
  parameter int CODE_BASE = 'h200,
  parameter int CODE_STEP = 'h20
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [LVL_W-1:0]   cpuMask,
  input logic               irqReq,
  input logic [LVL_W-1:0]   irqLevel,
  input logic [CODE_W-1:0]  irqCode
);

  logic [NUM_SRC-1:0] prevReq;
  logic [31:0]        codeOff;
  logic [31:0]        codeIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevReq <= '0;
    else       prevReq <= srcReq;
  end

  assign codeOff = 32'(irqCode) - 32'(CODE_BASE);
  assign codeIdx = codeOff / 32'(CODE_STEP);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !irqReq);

  // R5
  above_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqLevel > $past(cpuMask));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqLevel == '0 && irqCode == '0));

  // R9
  code_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqCode >= CODE_W'(CODE_BASE) && codeOff % 32'(CODE_STEP) == 0
                && codeIdx < 32'(NUM_SRC)));

  // R6
  src_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> prevReq[codeIdx[$clog2(NUM_SRC)-1:0]]);

endmodule

bind irq_prio_arbiter irq_arb_checker #(
  .NUM_SRC   (NUM_SRC),
  .LVL_W     (LVL_W),
  .CODE_W    (CODE_W),
  .CODE_BASE (CODE_BASE),
  .CODE_STEP (CODE_STEP)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .srcReq   (srcReq),
  .cpuMask  (cpuMask),
  .irqReq   (irqReq),
  .irqLevel (irqLevel),
  .irqCode  (irqCode)
);

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;

  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  srcReq = '0;
  logic [3:0]  cpuMask = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqReq;
  logic [3:0]  irqLevel;
  logic [11:0] irqCode;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk;

  irq_prio_arbiter dut_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .cpuMask(cpuMask),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq), .irqLevel(irqLevel), .irqCode(irqCode)
  );

  function automatic int expCode(int idx);
    return 'h200 + idx * 'h20;
  endfunction

  task automatic check(string tag, int act, int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output int d);
    @(negedge clk);
    regAddr = a;
    #1 d = int'(regRdData);
  endtask

  // drive request/mask at a falling edge, sample after one rising edge
  task automatic apply(logic [7:0] r, logic [3:0] m);
    @(negedge clk);
    srcReq = r; cpuMask = m;
    @(negedge clk);
  endtask

  task automatic expectOut(string tag, int req, int lvl, int code);
    check({tag, " req"}, int'(irqReq), req);
    check({tag, " level"}, int'(irqLevel), lvl);
    check({tag, " code"}, int'(irqCode), code);
  endtask

  task automatic testReset();
    int d;
    expectOut("R1 reset", 0, 0, 0);
    readReg(3'd2, d); check("R1 mask reset", d, 'h00FF);
    readReg(3'd0, d); check("R1 prio0 reset", d, 0);
    readReg(3'd1, d); check("R1 prio1 reset", d, 0);
    apply(8'hFF, 4'd0);
    expectOut("R1 all masked", 0, 0, 0);
    apply(8'h00, 4'd0);
  endtask

  task automatic testLayout();
    int d;
    writeReg(3'd0, 16'h4321);
    writeReg(3'd1, 16'h8765);
    readReg(3'd0, d); check("R11 prio0 readback", d, 'h4321);
    readReg(3'd1, d); check("R11 prio1 readback", d, 'h8765);
  endtask

  task automatic testMask();
    int d;
    writeReg(3'd3, 16'h00FF);
    readReg(3'd2, d); check("R8 clear all", d, 0);
    readReg(3'd3, d); check("R8 clear reads zero", d, 0);
    writeReg(3'd2, 16'h0005);
    readReg(3'd2, d); check("R7 set bits", d, 'h05);
    writeReg(3'd2, 16'h0000);
    readReg(3'd2, d); check("R7 zero no change", d, 'h05);
    writeReg(3'd3, 16'h0001);
    readReg(3'd2, d); check("R8 clear bit", d, 'h04);
    writeReg(3'd3, 16'h0000);
    readReg(3'd2, d); check("R8 zero no change", d, 'h04);
    writeReg(3'd3, 16'h00FF);
  endtask

  task automatic testDisabled();
    writeReg(3'd0, 16'h4320);   // src0 level 0
    apply(8'h01, 4'd0);
    expectOut("R2 level0 silent", 0, 0, 0);
  endtask

  task automatic testHighest();
    // src0=0, src2=3, src4=5
    apply(8'h15, 4'd0);
    expectOut("R3 highest", 1, 5, expCode(4));
    apply(8'h0C, 4'd0);        // src2=3, src3=4
    expectOut("R3 highest b", 1, 4, expCode(3));
  endtask

  task automatic testTie();
    writeReg(3'd0, 16'h6666);
    apply(8'h0E, 4'd0);
    expectOut("R4 tie low index", 1, 6, expCode(1));
    apply(8'h0C, 4'd0);
    expectOut("R4 tie next", 1, 6, expCode(2));
  endtask

  task automatic testStrict();
    apply(8'h02, 4'd6);
    expectOut("R5 equal rejected", 0, 0, 0);
    apply(8'h02, 4'd5);
    expectOut("R5 above accepted", 1, 6, expCode(1));
    apply(8'h02, 4'd15);
    expectOut("R5 high mask", 0, 0, 0);
  endtask

  task automatic testPending();
    writeReg(3'd2, 16'h0002);  // mask src1
    apply(8'h0E, 4'd0);
    expectOut("R6 masked skipped", 1, 6, expCode(2));
    writeReg(3'd3, 16'h0002);
    apply(8'h0E, 4'd0);
    expectOut("R6 unmasked returns", 1, 6, expCode(1));
    apply(8'h90, 4'd0);        // src4=5, src7=8
    expectOut("R6 top of two", 1, 8, expCode(7));
    apply(8'h10, 4'd0);
    expectOut("R6 loser kept", 1, 5, expCode(4));
  endtask

  task automatic testLatency();
    apply(8'h00, 4'd0);
    @(negedge clk);
    srcReq = 8'h80;
    #1 check("R10 before edge", int'(irqReq), 0);
    @(posedge clk); #1;
    expectOut("R10 after edge", 1, 8, expCode(7));
    @(negedge clk);
    srcReq = 8'h00;
    #1 check("R10 hold", int'(irqReq), 1);
    @(posedge clk); #1;
    expectOut("R10 drop", 0, 0, 0);
    check("R9 code grid", expCode(7), 'h2E0);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 8);
    if (!done) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLayout();
    testMask();
    testDisabled();
    testHighest();
    testTie();
    testStrict();
    testPending();
    testLatency();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule